// File: doc/BRIEF.md
# Ternary Weight Matrix Accumulator

This block computes one output channel of a dense layer whose weights are restricted to -1, 0 and +1. No multiplier is involved. Each cycle it can accept one chunk made of `LANES` signed activations and one 2-bit weight code per activation. Each lane passes its activation through unchanged, negates it, or forces it to zero. The gated lane values then enter a pipelined adder tree, and the tree's root feeds a signed running accumulator.

A run is a sequence of chunks. The final chunk of a run carries a last flag. Once the last chunk has drained through the tree, the full dot product appears on the output with a valid/ready handshake. The accumulator then restarts from zero for the next output channel. A start pulse abandons a partly accumulated run: it clears the accumulator and discards any chunks still in the tree. The lane count trades throughput against adder area. The accumulator is sized so that a run of up to `IN_LEN` activations cannot overflow.

Top module: `ternary_accum`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A lane with weight code 2'b01 (+1) adds its activation, read as a signed two's-complement value, to the run's sum.
- R3: A lane with weight code 2'b11 (-1) subtracts its signed activation from the run's sum.
- R4: A lane with weight code 2'b00 (zero) or the reserved code 2'b10 contributes nothing. Its operand into the adder tree is held at zero.
- R5: out_sum equals the sum of the contributions from every lane of every chunk accepted since the run began, up to and including the chunk accepted with in_last=1. Exactly one result is produced per run.
- R6: out_valid rises at the LEVELS+1-th rising edge, counting the edge that accepts the last chunk, where LEVELS = log2(LANES). With the default of 8 lanes this is the 4th edge.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_sum does not change.
- R8: From acceptance of a last chunk until the result handshake, in_ready is 0. Chunks offered during that time are not taken and do not affect any later result.
- R9: A start pulse, when in_ready is 1, clears the accumulator and drops every chunk still inside the adder tree. A chunk presented in the same cycle as start becomes the first chunk of the new run.
- R10: The accumulator is ACT_W + clog2(IN_LEN) + 1 bits wide (15 by default). A full run of IN_LEN activations at the most negative value gives the exact result, +8192 with code 2'b11 and -8192 with code 2'b01.
- R11: After a result handshake, out_valid is 0 on the next cycle, in_ready returns to 1, and the next run starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Abandons the current run and clears the accumulator |
| in_valid | input | 1 | A chunk is offered |
| in_ready | output | 1 | The block can take a chunk this cycle |
| in_last | input | 1 | The offered chunk ends the run |
| in_act | input | LANES*ACT_W | Signed activations; lane i occupies bits [i*ACT_W +: ACT_W] |
| in_wgt | input | LANES*2 | Weight codes; lane i occupies bits [2*i +: 2] |
| out_valid | output | 1 | out_sum holds a finished run result |
| out_ready | input | 1 | Consumer accepts the result |
| out_sum | output | ACC_W | Signed dot product of the run |

## Verification
Directed chunks with all weights set to +1, then all to -1, then all to zero or reserved, check each sign path and the gating in isolation. A wrong decode of one code cannot then be hidden by another code. Random runs of one to eight chunks, with a random mix of all four codes and random result back-pressure, show whether lanes and chunks are summed correctly across tree levels and run boundaries. Full-length runs at the most negative activation probe the accumulator width. Runs interrupted by start, both while chunks are still in the tree and after they have reached the accumulator, separate a correct flush from a stale partial sum.

// File: rtl/ternacc_pkg.sv
package ternacc_pkg;

  typedef enum logic [1:0] {
    WC_ZERO = 2'b00,
    WC_POS  = 2'b01,
    WC_RSV  = 2'b10,
    WC_NEG  = 2'b11
  } wcode_e;

  typedef struct packed {
    logic en;
    logic neg;
  } lane_ctl_t;

  // Maps a 2-bit weight code to lane enable and negate controls.
  function automatic lane_ctl_t decode_wcode(input logic [1:0] code);
    lane_ctl_t r;
    r.en  = 1'b0;
    r.neg = 1'b0;
    case (wcode_e'(code))
      WC_POS: r.en = 1'b1;
      WC_NEG: begin
        r.en  = 1'b1;
        r.neg = 1'b1;
      end
      default: r.en = 1'b0;
    endcase
    return r;
  endfunction

  // Accumulator width that holds len signed act_w-bit terms without overflow.
  function automatic int acc_width(input int act_w, input int len);
    return act_w + $clog2(len) + 1;
  endfunction

endpackage

// File: rtl/tern_lane_decode.sv
module tern_lane_decode
  import ternacc_pkg::*;
(
  input  logic [1:0] code,
  output logic       en,
  output logic       neg
);
  lane_ctl_t ctl;

  always_comb begin
    ctl = decode_wcode(code);
    en  = ctl.en;
    neg = ctl.neg;
  end
endmodule

// File: rtl/tern_sign_mux.sv
module tern_sign_mux #(
  parameter int ACT_W = 8,
  parameter int OUT_W = 15
) (
  input  logic [ACT_W-1:0] act,
  input  logic             en,
  input  logic             neg,
  output logic [OUT_W-1:0] val
);
  logic [ACT_W-1:0] gated;
  logic [OUT_W-1:0] ext;

  // AND gating keeps a disabled lane at zero so the tree sees no toggle.
  assign gated = act & {ACT_W{en}};
  assign ext   = {{(OUT_W-ACT_W){gated[ACT_W-1]}}, gated};
  assign val   = neg ? (~ext + 1'b1) : ext;
endmodule

// File: rtl/tern_adder_tree.sv
module tern_adder_tree #(
  parameter int LANES = 8,
  parameter int W     = 15,
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_vld,
  input  logic             in_last,
  input  logic [LANES*W-1:0] in_ops,
  output logic [W-1:0]     root,
  output logic             root_vld,
  output logic             root_last
);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int N = LANES >> (l + 1);
    logic vld_q;
    logic last_q;
    logic adv;

    if (l == 0) begin : g_first
      assign adv = in_vld;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          last_q <= 1'b0;
        end else begin
          vld_q  <= in_vld;
          last_q <= in_vld & in_last;
        end
      end
    end else begin : g_next
      assign adv = g_lvl[l-1].vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          last_q <= 1'b0;
        end else begin
          vld_q  <= g_lvl[l-1].vld_q & ~flush;
          last_q <= g_lvl[l-1].last_q & ~flush;
        end
      end
    end

    for (genvar i = 0; i < N; i++) begin : g_node
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] s;

      if (l == 0) begin : g_leaf
        assign a = in_ops[(2*i)*W +: W];
        assign b = in_ops[(2*i+1)*W +: W];
      end else begin : g_inner
        assign a = g_lvl[l-1].g_node[2*i].s;
        assign b = g_lvl[l-1].g_node[2*i+1].s;
      end

      // Registers only load when valid data arrives, limiting toggling.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s <= '0;
        else if (adv) s <= a + b;
      end
    end
  end

  assign root      = g_lvl[LEVELS-1].g_node[0].s;
  assign root_vld  = g_lvl[LEVELS-1].vld_q;
  assign root_last = g_lvl[LEVELS-1].last_q;

endmodule

// File: rtl/ternary_accum.sv
module ternary_accum
  import ternacc_pkg::*;
#(
  parameter int ACT_W  = 8,
  parameter int LANES  = 8,
  parameter int IN_LEN = 64,
  localparam int ACC_W  = acc_width(ACT_W, IN_LEN),
  localparam int LEVELS = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_last,
  input  logic [LANES*ACT_W-1:0] in_act,
  input  logic [LANES*2-1:0]     in_wgt,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ACC_W-1:0]       out_sum
);

  function automatic logic [ACC_W-1:0] acc_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  // Event wires, also observed by the checker.
  logic                   accept;
  logic                   start_eff;
  logic                   final_arrive;
  logic [LANES-1:0]       lane_en;
  logic [LANES-1:0]       lane_neg;
  logic [LANES-1:0]       lane_nz;
  logic [LANES*ACC_W-1:0] lane_ops;

  logic [ACC_W-1:0] root;
  logic             root_vld;
  logic             root_last;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] out_q;
  logic             out_vld_q;
  logic             last_pend_q;

  assign in_ready  = ~out_vld_q & ~last_pend_q;
  assign accept    = in_valid & in_ready;
  assign start_eff = start & in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tern_lane_decode u_dec (
      .code (in_wgt[2*i +: 2]),
      .en   (lane_en[i]),
      .neg  (lane_neg[i])
    );

    tern_sign_mux #(.ACT_W(ACT_W), .OUT_W(ACC_W)) u_mux (
      .act (in_act[i*ACT_W +: ACT_W]),
      .en  (lane_en[i] & accept),
      .neg (lane_neg[i]),
      .val (lane_ops[i*ACC_W +: ACC_W])
    );

    assign lane_nz[i] = |lane_ops[i*ACC_W +: ACC_W];
  end

  tern_adder_tree #(.LANES(LANES), .W(ACC_W)) u_tree (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_eff),
    .in_vld    (accept),
    .in_last   (in_last),
    .in_ops    (lane_ops),
    .root      (root),
    .root_vld  (root_vld),
    .root_last (root_last)
  );

  assign final_arrive = root_vld & root_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      out_q       <= '0;
      out_vld_q   <= 1'b0;
      last_pend_q <= 1'b0;
    end else begin
      if (start_eff) acc_q <= '0;
      else if (final_arrive) acc_q <= '0;
      else if (root_vld) acc_q <= acc_add(acc_q, root);

      if (final_arrive) begin
        out_q     <= acc_add(acc_q, root);
        out_vld_q <= 1'b1;
      end else if (out_vld_q && out_ready) begin
        out_vld_q <= 1'b0;
      end

      if (accept && in_last) last_pend_q <= 1'b1;
      else if (final_arrive) last_pend_q <= 1'b0;
    end
  end

  assign out_valid = out_vld_q;
  assign out_sum   = out_q;

endmodule

// File: rtl/ternary_accum_chk.sv
module ternary_accum_chk #(
  parameter int LANES  = 8,
  parameter int ACC_W  = 15,
  parameter int LEVELS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_sum,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] lane_nz
);
  logic [7:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (in_valid && in_ready && in_last) lat_cnt <= 8'(LEVELS);
    else if (lat_cnt != 0) lat_cnt <= lat_cnt - 1'b1;
  end

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_nz & ~lane_en) == 0);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_cnt == 1) |=> out_valid);

  assert_no_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(lat_cnt) == 1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

endmodule

bind ternary_accum ternary_accum_chk #(
  .LANES(LANES), .ACC_W(ACC_W), .LEVELS(LEVELS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .lane_en   (lane_en),
  .lane_nz   (lane_nz)
);

// File: tb/ternary_accum_tb.sv
module ternary_accum_tb_top;
  localparam int ACT_W  = 8;
  localparam int LANES  = 8;
  localparam int IN_LEN = 64;
  localparam int ACC_W  = 15;
  localparam int LAT    = 4;   // edges from last acceptance to out_valid

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic                   in_last = 1'b0;
  logic [LANES*ACT_W-1:0] in_act = '0;
  logic [LANES*2-1:0]     in_wgt = '0;
  logic                   out_valid;
  logic                   out_ready = 1'b0;
  logic [ACC_W-1:0]       out_sum;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ternary_accum #(.ACT_W(ACT_W), .LANES(LANES), .IN_LEN(IN_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference: each weight code becomes an integer factor.
  function automatic longint chunk_ref(input logic [LANES*ACT_W-1:0] a,
                                       input logic [LANES*2-1:0] w);
    int factor [4] = '{0, 1, 0, -1};
    longint s = 0;
    for (int i = 0; i < LANES; i++)
      s += factor[w[2*i +: 2]] * longint'($signed(a[i*ACT_W +: ACT_W]));
    return s;
  endfunction

  task automatic send(input logic [LANES*ACT_W-1:0] a, input logic [LANES*2-1:0] w,
                      input bit last, input bit st);
    @(negedge clk);
    in_act = a; in_wgt = w; in_last = last; start = st; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0; start = 1'b0; in_last = 1'b0;
  endtask

  // Collects a result after the last chunk's acceptance edge.
  task automatic get_result(input longint exp, input int hold, input bit offer, input string req);
    int n = 0;
    logic [ACC_W-1:0] seen;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 40);
    check(n == LAT, "R6 latency", n, LAT);
    check(longint'($signed(out_sum)) == exp, req, longint'($signed(out_sum)), exp);
    check(in_ready == 1'b0, "R8 ready low", in_ready, 0);
    seen = out_sum;
    if (offer) begin
      in_act = {LANES{8'd100}}; in_wgt = {LANES{2'b01}}; in_last = 1'b1; in_valid = 1'b1;
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(out_valid && out_sum == seen, "R7 hold", out_sum, seen);
    end
    in_valid = 1'b0; in_last = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R11 release", {out_valid, in_ready}, 1);
  endtask

  task automatic run_random(input int nchunks, input int hold);
    longint exp = 0;
    for (int c = 0; c < nchunks; c++) begin
      logic [LANES*ACT_W-1:0] a;
      logic [LANES*2-1:0] w;
      for (int i = 0; i < LANES; i++) begin
        a[i*ACT_W +: ACT_W] = ACT_W'($urandom);
        w[2*i +: 2] = 2'($urandom);
      end
      exp += chunk_ref(a, w);
      send(a, w, c == nchunks - 1, 1'b0);
      if ($urandom % 4 == 0 && c != nchunks - 1) repeat ($urandom % 3) @(negedge clk);
    end
    get_result(exp, hold, 1'b0, "R5 random run");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [LANES*ACT_W-1:0] a1, a2, a3;
    int seed_set;
    seed_set = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);

    a1 = {8'd7, -8'sd3, 8'd127, -8'sd128, 8'd1, 8'd0, -8'sd50, 8'd33};
    // R2: all +1
    send(a1, {LANES{2'b01}}, 1'b1, 1'b0);
    get_result(chunk_ref(a1, {LANES{2'b01}}), 0, 1'b0, "R2 plus");
    // R3: all -1
    send(a1, {LANES{2'b11}}, 1'b1, 1'b0);
    get_result(chunk_ref(a1, {LANES{2'b11}}), 1, 1'b0, "R3 minus");
    // R4: zero and reserved codes
    send({LANES{8'd99}}, {4{2'b10, 2'b00}}, 1'b1, 1'b0);
    get_result(0, 0, 1'b0, "R4 zero/reserved");
    // R4: single active lane among gated ones
    send({LANES{8'd99}}, {2'b10, 2'b00, 2'b10, 2'b01, 2'b00, 2'b10, 2'b00, 2'b00}, 1'b1, 1'b0);
    get_result(99, 0, 1'b0, "R4 one lane");

    // R8: chunks offered while result pending are ignored; R11 next run from zero
    send(a1, {LANES{2'b01}}, 1'b1, 1'b0);
    get_result(chunk_ref(a1, {LANES{2'b01}}), 3, 1'b1, "R8 base");
    send(a1, {LANES{2'b11}}, 1'b1, 1'b0);
    get_result(chunk_ref(a1, {LANES{2'b11}}), 0, 1'b0, "R8 R11 after offer");

    // R10: full-length extreme runs
    for (int c = 0; c < IN_LEN / LANES; c++)
      send({LANES{8'h80}}, {LANES{2'b11}}, c == IN_LEN / LANES - 1, 1'b0);
    get_result(8192, 0, 1'b0, "R10 max positive");
    for (int c = 0; c < IN_LEN / LANES; c++)
      send({LANES{8'h80}}, {LANES{2'b01}}, c == IN_LEN / LANES - 1, 1'b0);
    get_result(-8192, 0, 1'b0, "R10 max negative");

    // R9: start while earlier chunks are still inside the tree
    a2 = {LANES{8'd50}};
    a3 = {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
    send(a2, {LANES{2'b01}}, 1'b0, 1'b0);
    send(a2, {LANES{2'b01}}, 1'b0, 1'b0);
    send(a3, {LANES{2'b01}}, 1'b1, 1'b1);
    get_result(36, 0, 1'b0, "R9 flush tree");
    // R9: start after partial sum reached the accumulator
    send(a2, {LANES{2'b11}}, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    send(a3, {LANES{2'b11}}, 1'b0, 1'b1);
    send(a3, {LANES{2'b01}}, 1'b1, 1'b0);
    get_result(0, 0, 1'b0, "R9 clear acc");

    // R5: random runs
    for (int r = 0; r < 40; r++)
      run_random(1 + $urandom % (IN_LEN / LANES), $urandom % 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule